// File: doc/BRIEF.md
# Coprocessor Trap Decision Unit

This block keeps four low control bits of a processor control register and, for each instruction presented to it, decides whether the instruction may run or must raise the device-not-available exception (vector 7). The bits are a protection-enable bit, a wait-monitor bit, a floating-point emulation bit and a context-switched flag.

Software loads all four bits through a write port. A one-cycle task-switch pulse sets the context-switched flag in hardware. A clear strobe lets software drop that flag once it has saved the old floating-point state. The instruction decoder gives each instruction a class. A floating-point instruction traps when emulation is on or the context-switched flag is up. A WAIT instruction traps only when both the context-switched flag and the wait-monitor bit are set. Emulation has no effect on WAIT.

The fault request is registered and carries the vector number in its vector field. A real-mode output mirrors a cleared protection-enable bit for the rest of the core.

Top module: `cpx_trap_unit`

## Requirements
- R1: After reset all four control bits are 0. `real_mode` is 1, `fault_req` is 0 and `fault_vec` is 0. A floating-point or WAIT instruction issued right after reset does not fault.
- R2: A cycle with `wr_en`=1 loads `wr_data` into all four bits at the next clock edge. The layout is bit 0 protection enable, bit 1 wait monitor, bit 2 floating-point emulation and bit 3 context-switched flag. An instruction in the same cycle as the write is judged on the old bit values.
- R3: `task_sw`=1 sets the context-switched flag at the next edge. This overrides a clear strobe and a written value of 0 in the same cycle.
- R4: `clr_flag`=1 without `task_sw` clears the context-switched flag. It wins over a written 1 in the same cycle and leaves the other three bits unchanged.
- R5: A floating-point instruction (class 2'b01) faults when emulation is 1 or the context-switched flag is 1. The wait-monitor bit has no effect. With both emulation and the flag at 0 it executes.
- R6: A WAIT instruction (class 2'b10) faults only when the context-switched flag and the wait monitor are both 1. Emulation has no effect on it.
- R7: Classes 2'b00 and 2'b11 never fault, whatever the control bits hold.
- R8: `fault_req` rises in the cycle after a qualifying `ins_valid` cycle and stays high for exactly one cycle per such cycle. While it is high, `fault_vec` is 7. While it is low, `fault_vec` is 0.
- R9: `real_mode` is the inverse of the protection-enable bit and follows it from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write of the control bits |
| wr_data | input | 4 | Value written to the control bits |
| task_sw | input | 1 | Hardware task-switch pulse |
| clr_flag | input | 1 | Software clear of the context-switched flag |
| ins_valid | input | 1 | An instruction is presented this cycle |
| ins_class | input | 2 | 00 other, 01 floating-point, 10 WAIT, 11 other |
| fault_req | output | 1 | Registered exception request |
| fault_vec | output | 8 | Exception vector number |
| real_mode | output | 1 | Protection disabled |

## Verification
The context-switched flag has three writers: the task-switch pulse, the clear strobe and a software write. These can land in the same cycle. The bench drives each pair together on one falling edge. It then reads the resulting flag back through the fault decision of a WAIT instruction, issued with the wait monitor set. A second case puts an instruction in the same cycle as a write. That instruction must be judged on the bits from before the write, and the next instruction on the new bits.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

   typedef enum logic [1:0] {
      CLS_OTHER = 2'b00,
      CLS_FP    = 2'b01,
      CLS_WAIT  = 2'b10,
      CLS_RSVD  = 2'b11
   } ins_cls_e;

   localparam int unsigned CTRL_BITS  = 4;
   localparam int unsigned BIT_PROT   = 0;
   localparam int unsigned BIT_WWATCH = 1;
   localparam int unsigned BIT_FPEMU  = 2;
   localparam int unsigned BIT_CTXSW  = 3;

   typedef struct packed {
      logic ctxsw;
      logic fpemu;
      logic wwatch;
      logic prot;
   } ctrl_t;

endpackage

// File: rtl/cpx_ctrl_reg.sv
module cpx_ctrl_reg
   import cpx_pkg::*;
#(
   parameter int unsigned CTRL_W = CTRL_BITS
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              task_sw,
   input  logic              clr_flag,
   output logic [CTRL_W-1:0] ctrl_q
);

   for (genvar g = 0; g < CTRL_W; g++) begin : g_bit
      logic bit_q;
      logic bit_d;

      if (g == BIT_CTXSW) begin : g_flag
         // hardware set beats software clear beats software write
         always_comb begin
            if (task_sw)       bit_d = 1'b1;
            else if (clr_flag) bit_d = 1'b0;
            else if (wr_en)    bit_d = wr_data[g];
            else               bit_d = bit_q;
         end
      end else begin : g_plain
         always_comb bit_d = wr_en ? wr_data[g] : bit_q;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) bit_q <= 1'b0;
         else        bit_q <= bit_d;
      end

      assign ctrl_q[g] = bit_q;
   end

endmodule

// File: rtl/cpx_trap_rule.sv
module cpx_trap_rule
   import cpx_pkg::*;
(
   input  ctrl_t    ctrl,
   input  logic     ins_valid,
   input  ins_cls_e ins_class,
   output logic     trap
);

   logic fp_trap;
   logic wait_trap;

   // emulation or a pending context switch stops floating-point work
   assign fp_trap   = ctrl.fpemu | ctrl.ctxsw;
   // WAIT only stops when monitoring is on and a switch is pending
   assign wait_trap = ctrl.ctxsw & ctrl.wwatch;

   always_comb begin
      trap = 1'b0;
      if (ins_valid) begin
         unique case (ins_class)
            CLS_FP:   trap = fp_trap;
            CLS_WAIT: trap = wait_trap;
            default:  trap = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/cpx_fault_out.sv
module cpx_fault_out #(
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned TRAP_VEC  = 7,
   parameter bit          IDLE_ZERO = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trap,
   output logic             fault_req,
   output logic [VEC_W-1:0] fault_vec
);

   localparam logic [VEC_W-1:0] VEC_CODE = VEC_W'(TRAP_VEC);

   always_ff @(posedge clk) begin
      if (!rst_n) fault_req <= 1'b0;
      else        fault_req <= trap;
   end

   if (IDLE_ZERO) begin : g_gated
      assign fault_vec = fault_req ? VEC_CODE : '0;
   end else begin : g_const
      assign fault_vec = VEC_CODE;
   end

endmodule

// File: rtl/cpx_trap_unit.sv
module cpx_trap_unit
   import cpx_pkg::*;
#(
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned TRAP_VEC  = 7,
   parameter bit          IDLE_ZERO = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [3:0]       wr_data,
   input  logic             task_sw,
   input  logic             clr_flag,
   input  logic             ins_valid,
   input  logic [1:0]       ins_class,
   output logic             fault_req,
   output logic [VEC_W-1:0] fault_vec,
   output logic             real_mode
);

   localparam int unsigned VEC_NEED = $clog2(TRAP_VEC + 1);

   if (VEC_W < VEC_NEED) begin : g_bad_vec
      $error("vector field too narrow for trap number");
   end
   if (VEC_W > 32) begin : g_bad_wide
      $error("vector field wider than 32 bits");
   end

   logic [CTRL_BITS-1:0] ctrl_q;
   ctrl_t                ctrl_s;
   logic                 trap;

   cpx_ctrl_reg #(.CTRL_W(CTRL_BITS)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .task_sw  (task_sw),
      .clr_flag (clr_flag),
      .ctrl_q   (ctrl_q)
   );

   assign ctrl_s = ctrl_t'(ctrl_q);

   cpx_trap_rule u_rule (
      .ctrl      (ctrl_s),
      .ins_valid (ins_valid),
      .ins_class (ins_cls_e'(ins_class)),
      .trap      (trap)
   );

   cpx_fault_out #(
      .VEC_W     (VEC_W),
      .TRAP_VEC  (TRAP_VEC),
      .IDLE_ZERO (IDLE_ZERO)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .trap      (trap),
      .fault_req (fault_req),
      .fault_vec (fault_vec)
   );

   assign real_mode = ~ctrl_s.prot;

endmodule

// File: rtl/cpx_trap_chk.sv
module cpx_trap_chk #(
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned TRAP_VEC = 7
)(
   input logic             clk,
   input logic             rst_n,
   input logic             task_sw,
   input logic             clr_flag,
   input logic             ins_valid,
   input logic [1:0]       ins_class,
   input logic [3:0]       ctrl_q,
   input logic             fault_req,
   input logic [VEC_W-1:0] fault_vec
);

   // R3
   task_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      task_sw |=> ctrl_q[3]);

   // R4
   clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_flag && !task_sw) |=> !ctrl_q[3]);

   // R5
   fp_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && ins_class == 2'b01 && (ctrl_q[2] || ctrl_q[3])) |=> fault_req);

   // R6
   wait_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && ins_class == 2'b10 && !(ctrl_q[3] && ctrl_q[1])) |=> !fault_req);

   // R7
   other_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && (ins_class == 2'b00 || ins_class == 2'b11)) |=> !fault_req);

   // R8
   vec_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_req |-> fault_vec == VEC_W'(TRAP_VEC));

   // R8
   no_stray_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ins_valid |=> !fault_req);

endmodule

bind cpx_trap_unit cpx_trap_chk #(.VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .task_sw   (task_sw),
   .clr_flag  (clr_flag),
   .ins_valid (ins_valid),
   .ins_class (ins_class),
   .ctrl_q    (ctrl_q),
   .fault_req (fault_req),
   .fault_vec (fault_vec)
);

// File: tb/tb_cpx_trap_unit.sv
module tb_cpx_trap_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_data = '0;
   logic       task_sw = 1'b0;
   logic       clr_flag = 1'b0;
   logic       ins_valid = 1'b0;
   logic [1:0] ins_class = '0;
   logic       fault_req;
   logic [7:0] fault_vec;
   logic       real_mode;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   cpx_trap_unit dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .task_sw(task_sw), .clr_flag(clr_flag), .ins_valid(ins_valid),
      .ins_class(ins_class), .fault_req(fault_req), .fault_vec(fault_vec),
      .real_mode(real_mode)
   );

   localparam logic [1:0] C_OTH = 2'b00, C_FP = 2'b01, C_WT = 2'b10, C_RS = 2'b11;

   // entry: {ctrl[3:0] (3 flag,2 emul,1 monitor,0 prot), class, expected fault}
   localparam int NV = 14;
   localparam logic [6:0] VTAB [NV] = '{
      {4'b0000, C_FP,  1'b0}, {4'b0010, C_FP,  1'b0}, {4'b0100, C_FP,  1'b1},
      {4'b1000, C_FP,  1'b1}, {4'b1010, C_FP,  1'b1}, {4'b0110, C_FP,  1'b1},
      {4'b0111, C_FP,  1'b1}, {4'b1000, C_WT,  1'b0}, {4'b1010, C_WT,  1'b1},
      {4'b0010, C_WT,  1'b0}, {4'b0110, C_WT,  1'b0}, {4'b1110, C_WT,  1'b1},
      {4'b1111, C_OTH, 1'b0}, {4'b1111, C_RS,  1'b0}
   };

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] v, logic ts, logic clr);
      @(negedge clk);
      wr_en = 1'b1; wr_data = v; task_sw = ts; clr_flag = clr;
      @(negedge clk);
      wr_en = 1'b0; task_sw = 1'b0; clr_flag = 1'b0;
   endtask

   task automatic strobe(logic ts, logic clr);
      @(negedge clk);
      task_sw = ts; clr_flag = clr;
      @(negedge clk);
      task_sw = 1'b0; clr_flag = 1'b0;
   endtask

   task automatic issue(logic [1:0] c, output logic f);
      @(negedge clk);
      ins_valid = 1'b1; ins_class = c;
      @(negedge clk);
      ins_valid = 1'b0;
      f = fault_req;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic f;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 fault_req", {7'b0, fault_req}, 8'd0);
      chk("R1 fault_vec", fault_vec, 8'd0);
      chk("R1 real_mode", {7'b0, real_mode}, 8'd1);
      issue(C_FP, f); chk("R1 fp after reset", {7'b0, f}, 8'd0);
      issue(C_WT, f); chk("R1 wait after reset", {7'b0, f}, 8'd0);

      // table walk: R5 R6 R7 R9 R8
      for (int i = 0; i < NV; i++) begin
         wr(VTAB[i][6:3], 1'b0, 1'b0);
         chk("R9 real_mode", {7'b0, real_mode}, {7'b0, ~VTAB[i][3]});
         issue(VTAB[i][2:1], f);
         chk(VTAB[i][2:1] == C_FP ? "R5 fp" :
             VTAB[i][2:1] == C_WT ? "R6 wait" : "R7 other",
             {7'b0, f}, {7'b0, VTAB[i][0]});
         chk("R8 vec", fault_vec, VTAB[i][0] ? 8'd7 : 8'd0);
         @(negedge clk);
         chk("R8 one cycle", {7'b0, fault_req}, 8'd0);
      end

      // R3 task switch alone sets flag
      wr(4'b0010, 1'b0, 1'b0);
      strobe(1'b1, 1'b0);
      issue(C_WT, f); chk("R3 task pulse", {7'b0, f}, 8'd1);
      // R4 clear alone
      strobe(1'b0, 1'b1);
      issue(C_WT, f); chk("R4 clear", {7'b0, f}, 8'd0);
      // R3 task beats clear
      strobe(1'b1, 1'b1);
      issue(C_WT, f); chk("R3 task over clear", {7'b0, f}, 8'd1);
      // R3 task beats written 0
      wr(4'b0010, 1'b1, 1'b0);
      issue(C_WT, f); chk("R3 task over write", {7'b0, f}, 8'd1);
      // R4 clear beats written 1
      wr(4'b1010, 1'b0, 1'b1);
      issue(C_WT, f); chk("R4 clear over write", {7'b0, f}, 8'd0);
      // R4 clear leaves other bits
      wr(4'b1111, 1'b0, 1'b0);
      strobe(1'b0, 1'b1);
      issue(C_FP, f); chk("R4 emul kept", {7'b0, f}, 8'd1);
      issue(C_WT, f); chk("R4 wait after clear", {7'b0, f}, 8'd0);
      chk("R4 prot kept", {7'b0, real_mode}, 8'd0);

      // R2 instruction in write cycle sees old bits
      wr(4'b0000, 1'b0, 1'b0);
      @(negedge clk);
      wr_en = 1'b1; wr_data = 4'b0100; ins_valid = 1'b1; ins_class = C_FP;
      @(negedge clk);
      wr_en = 1'b0; ins_valid = 1'b0;
      chk("R2 old bits", {7'b0, fault_req}, 8'd0);
      issue(C_FP, f); chk("R2 new bits", {7'b0, f}, 8'd1);

      // R8 back to back faults, then drop
      @(negedge clk);
      ins_valid = 1'b1; ins_class = C_FP;
      @(negedge clk);
      chk("R8 first", {7'b0, fault_req}, 8'd1);
      @(negedge clk);
      ins_valid = 1'b0;
      chk("R8 second", {7'b0, fault_req}, 8'd1);
      @(negedge clk);
      chk("R8 drop", {7'b0, fault_req}, 8'd0);
      chk("R8 idle vec", fault_vec, 8'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule